// File: doc/BRIEF.md
# Command Write-Protect and Passkey Gate

This block sits between the command decoder of a power-management serial bus and the configuration registers of a digitally controlled converter. Each register write reaches it as a command code, a 16-bit data word, a strobe and a one-hot group vector from an external command-to-group decoder. One cycle later the block answers with either an accept pulse or a reject pulse. The configuration register applies the write only on accept. The host interface can turn a reject into a data or command fault.

The block holds four pieces of state: a 16-bit per-group protection mask, a legacy write-protect byte, a 16-bit passkey, and a failure counter. The mask can block its own register, the passkey register, and the store-to-NVM command. A nonzero passkey locks the mask register and the store command. The lock lifts when the same key is written back. Only three wrong keys are tolerated per power cycle.

The key logic is a four-state machine:
- **BOOT** is entered on reset and lasts one cycle. It loads the boot values. It moves to **LOCKED** if the boot key is nonzero, and to **OPEN** otherwise.
- **OPEN** moves to **LOCKED** on a key write with nonzero data.
- **LOCKED** moves to **OPEN** when the matching key is written. It moves to **SEALED** on the third wrong key.
- **SEALED** is left only by reset.

Top module: `wpg_gate`

## Requirements
- R1: While reset is low, every output is zero. At the first clock edge after reset, the mask, legacy byte and key load from the boot inputs. The lock is set exactly when the boot key is nonzero. A write in that cycle is rejected.
- R2: An ordinary write is rejected when any bit of the group vector matches a set mask bit. Bit i of the group vector and of the mask is group i: CFG = bit 6, OP = bit 7, VOUT = bit 12.
- R3: With mask, legacy byte and key all zero, every write is accepted.
- R4: While mask bit 15 is set, writes to code FBh (the mask register) are rejected. Bit 15 therefore stays set until reset.
- R5: While mask bit 1 is set, writes to code FAh (the key register) are rejected. While unlocked and with bit 15 clear, FBh writes are accepted and replace the mask.
- R6: While locked, writes to FBh and to code 15h (store to NVM) are rejected. A 15h write is also rejected while mask bit 0 is set.
- R7: A permitted FAh write works as follows:
  - When unlocked, it loads the key, is accepted, and sets the lock if the data is nonzero.
  - When locked and the data matches the key, it clears the lock and is accepted.
  - When locked and the data does not match, it is rejected and the failure count rises by one.
- R8: After three failures, every FAh write is rejected and the lock stays set until reset. Reset returns the count to zero.
- R9: Code 10h writes the legacy byte and is rejected while mask bit 14 is set. The legacy byte restricts ordinary writes:
  - 80h blocks all ordinary writes.
  - 40h blocks all except the OP group.
  - 20h blocks all except the OP and VOUT groups.
  - Any other value has no effect.
- R10: A rejected write leaves the mask, the legacy byte and the lock unchanged.
- R11: Each strobe gives exactly one of the accept or reject pulses, in the following cycle. A cycle without a strobe gives neither pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| boot_mask | input | 16 | Boot value of the protection mask |
| boot_legacy | input | 8 | Boot value of the legacy byte |
| boot_key | input | 16 | Boot value of the passkey |
| wr_en | input | 1 | Write strobe |
| wr_cmd | input | 8 | Command code of the write |
| wr_data | input | 16 | Data word of the write |
| grp_sel | input | 16 | One-hot group of the command |
| wr_ok | output | 1 | Accept pulse |
| wr_bad | output | 1 | Reject pulse |
| ext_mask | output | 16 | Current protection mask |
| legacy_wp | output | 8 | Current legacy byte |
| key_locked | output | 1 | Passkey lock active |
| fail_count | output | 2 | Wrong-key attempts this power cycle |

## Verification
The bench goes after four corner cases:
- **The key that is right only after exhaustion.** A design that compared the key before checking the failure limit would unlock in SEALED.
- **The failure count across an unlock.** A design that reset the count on a correct key would give an attacker unlimited guesses.
- **A mask rewrite that would clear bit 15.** A design that let it through would lose the hardware lock.
- **A wrong key.** A design that stored the mismatched value, or changed the mask on a rejected write, shows up in the register outputs that the bench compares every cycle against its model.

// File: rtl/wpg_pkg.sv
package wpg_pkg;
    localparam logic [7:0] CMD_LEGACY_WP = 8'h10;
    localparam logic [7:0] CMD_STORE     = 8'h15;
    localparam logic [7:0] CMD_KEY       = 8'hFA;
    localparam logic [7:0] CMD_MASK      = 8'hFB;

    localparam int BIT_HWP  = 15;
    localparam int BIT_WP   = 14;
    localparam int BIT_VOUT = 12;
    localparam int BIT_OP   = 7;
    localparam int BIT_PSK  = 1;
    localparam int BIT_STR  = 0;

    typedef enum logic [1:0] {
        ST_BOOT   = 2'd0,
        ST_OPEN   = 2'd1,
        ST_LOCKED = 2'd2,
        ST_SEALED = 2'd3
    } key_state_t;
endpackage

// File: rtl/wpg_key_fsm.sv
module wpg_key_fsm
    import wpg_pkg::*;
#(
    parameter int W         = 16,
    parameter int MAX_FAILS = 3,
    parameter int FAIL_W    = $clog2(MAX_FAILS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      boot_key,
    input  logic              try_wr,
    input  logic [W-1:0]      wdata,
    output key_state_t        state,
    output logic              key_ok,
    output logic              locked,
    output logic [FAIL_W-1:0] fail_cnt
);
    key_state_t        state_n;
    logic [W-1:0]      key_q, key_n;
    logic [FAIL_W-1:0] fail_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_BOOT;
            key_q    <= '0;
            fail_cnt <= '0;
        end else begin
            state    <= state_n;
            key_q    <= key_n;
            fail_cnt <= fail_n;
        end
    end

    // transitions
    always_comb begin
        state_n = state;
        key_n   = key_q;
        fail_n  = fail_cnt;
        unique case (state)
            ST_BOOT: begin
                key_n   = boot_key;
                state_n = (boot_key != '0) ? ST_LOCKED : ST_OPEN;
            end
            ST_OPEN: begin
                if (try_wr) begin
                    key_n = wdata;
                    if (wdata != '0) state_n = ST_LOCKED;
                end
            end
            ST_LOCKED: begin
                if (try_wr) begin
                    if (wdata == key_q) begin
                        state_n = ST_OPEN;
                    end else begin
                        fail_n = fail_cnt + FAIL_W'(1);
                        if (fail_n == FAIL_W'(MAX_FAILS)) state_n = ST_SEALED;
                    end
                end
            end
            ST_SEALED: begin
                state_n = ST_SEALED;
            end
        endcase
    end

    // outputs
    always_comb begin
        key_ok = try_wr && ((state == ST_OPEN) ||
                            (state == ST_LOCKED && wdata == key_q));
        locked = (state == ST_LOCKED) || (state == ST_SEALED);
    end

    assert_sealed_sticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        state == ST_SEALED |=> state == ST_SEALED);

    assert_fail_monotonic_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fail_cnt >= $past(fail_cnt));

    assert_fail_bounded_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fail_cnt <= FAIL_W'(MAX_FAILS));
endmodule

// File: rtl/wpg_rule.sv
module wpg_rule
    import wpg_pkg::*;
#(
    parameter int W  = 16,
    parameter int LW = 8
) (
    input  logic [W-1:0]  grp_sel,
    input  logic [W-1:0]  mask,
    input  logic [LW-1:0] legacy,
    output logic          ord_ok
);
    localparam logic [W-1:0] OP_ONLY = W'(1) << BIT_OP;
    localparam logic [W-1:0] OP_VOUT = OP_ONLY | (W'(1) << BIT_VOUT);

    logic hit;
    logic leg_ok;

    always_comb begin
        hit = |(grp_sel & mask);
        case (legacy)
            LW'(8'h80): leg_ok = 1'b0;
            LW'(8'h40): leg_ok = (grp_sel & ~OP_ONLY) == '0;
            LW'(8'h20): leg_ok = (grp_sel & ~OP_VOUT) == '0;
            default:    leg_ok = 1'b1;
        endcase
        ord_ok = !hit && leg_ok;
    end
endmodule

// File: rtl/wpg_gate.sv
module wpg_gate
    import wpg_pkg::*;
#(
    parameter int W         = 16,
    parameter int CW        = 8,
    parameter int LW        = 8,
    parameter int MAX_FAILS = 3,
    parameter int FAIL_W    = $clog2(MAX_FAILS + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      boot_mask,
    input  logic [LW-1:0]     boot_legacy,
    input  logic [W-1:0]      boot_key,
    input  logic              wr_en,
    input  logic [CW-1:0]     wr_cmd,
    input  logic [W-1:0]      wr_data,
    input  logic [W-1:0]      grp_sel,
    output logic              wr_ok,
    output logic              wr_bad,
    output logic [W-1:0]      ext_mask,
    output logic [LW-1:0]     legacy_wp,
    output logic              key_locked,
    output logic [FAIL_W-1:0] fail_count
);
    key_state_t state;
    logic in_boot, is_mask, is_key, is_wp, is_store;
    logic try_key, key_ok, ord_ok, grant;

    always_comb begin
        in_boot  = (state == ST_BOOT);
        is_mask  = (wr_cmd == CW'(CMD_MASK));
        is_key   = (wr_cmd == CW'(CMD_KEY));
        is_wp    = (wr_cmd == CW'(CMD_LEGACY_WP));
        is_store = (wr_cmd == CW'(CMD_STORE));
        try_key  = wr_en && is_key && !ext_mask[BIT_PSK] && !in_boot;
    end

    wpg_key_fsm #(.W(W), .MAX_FAILS(MAX_FAILS), .FAIL_W(FAIL_W)) u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .boot_key (boot_key),
        .try_wr   (try_key),
        .wdata    (wr_data),
        .state    (state),
        .key_ok   (key_ok),
        .locked   (key_locked),
        .fail_cnt (fail_count)
    );

    wpg_rule #(.W(W), .LW(LW)) u_rule (
        .grp_sel (grp_sel),
        .mask    (ext_mask),
        .legacy  (legacy_wp),
        .ord_ok  (ord_ok)
    );

    // decision
    always_comb begin
        grant = 1'b0;
        if (!in_boot) begin
            if (is_mask)       grant = !ext_mask[BIT_HWP] && !key_locked;
            else if (is_key)   grant = key_ok;
            else if (is_wp)    grant = !ext_mask[BIT_WP];
            else if (is_store) grant = !ext_mask[BIT_STR] && !key_locked;
            else               grant = ord_ok;
        end
    end

    // registers and response pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_mask  <= '0;
            legacy_wp <= '0;
            wr_ok     <= 1'b0;
            wr_bad    <= 1'b0;
        end else begin
            if (in_boot) begin
                ext_mask  <= boot_mask;
                legacy_wp <= boot_legacy;
            end else if (wr_en && grant) begin
                if (is_mask) ext_mask  <= wr_data;
                if (is_wp)   legacy_wp <= wr_data[LW-1:0];
            end
            wr_ok  <= wr_en && grant;
            wr_bad <= wr_en && !grant;
        end
    end

    assert_one_reply_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (wr_ok != wr_bad));

    assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> (!wr_ok && !wr_bad));

    assert_reject_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_bad && !$past(in_boot)) |->
            (ext_mask == $past(ext_mask) && legacy_wp == $past(legacy_wp) &&
             key_locked == $past(key_locked)));

    assert_hwp_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ext_mask[BIT_HWP] |=> ext_mask[BIT_HWP]);

    assert_store_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && is_store && key_locked) |=> wr_bad);
endmodule

// File: tb/sim_wpg_gate.sv
module sim_wpg_gate;
    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst_n = 1'b0;
    logic [15:0] boot_mask = '0, boot_key = '0;
    logic [7:0]  boot_legacy = '0;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_cmd = '0;
    logic [15:0] wr_data = '0, grp_sel = '0;
    logic        wr_ok, wr_bad, key_locked;
    logic [15:0] ext_mask;
    logic [7:0]  legacy_wp;
    logic [1:0]  fail_count;

    wpg_gate u0 (
        .clk(clk), .rst_n(rst_n), .boot_mask(boot_mask), .boot_legacy(boot_legacy),
        .boot_key(boot_key), .wr_en(wr_en), .wr_cmd(wr_cmd), .wr_data(wr_data),
        .grp_sel(grp_sel), .wr_ok(wr_ok), .wr_bad(wr_bad), .ext_mask(ext_mask),
        .legacy_wp(legacy_wp), .key_locked(key_locked), .fail_count(fail_count)
    );

    int total = 0, bad = 0;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    logic [15:0] m_mask = '0, m_key = '0;
    logic [7:0]  m_leg = '0;
    bit          m_lock = 0, m_boot = 1, e_ok = 0, e_bad = 0;
    int          m_fail = 0;

    function automatic bit leg_allows(input logic [7:0] l, input logic [15:0] g);
        if (l == 8'h80) return 0;
        if (l == 8'h40) return (g & ~16'h0080) == 0;
        if (l == 8'h20) return (g & ~16'h1080) == 0;
        return 1;
    endfunction

    always @(posedge clk) begin
        bit g;
        if (!rst_n) begin
            m_mask = '0; m_key = '0; m_leg = '0; m_lock = 0; m_fail = 0;
            m_boot = 1; e_ok = 0; e_bad = 0;
        end else if (m_boot) begin
            m_mask = boot_mask; m_leg = boot_legacy; m_key = boot_key;
            m_lock = (boot_key != 0); m_boot = 0; e_ok = 0; e_bad = wr_en;
        end else begin
            g = 0;
            if (wr_en) begin
                if (wr_cmd == 8'hFB) begin
                    g = !m_mask[15] && !m_lock;
                    if (g) m_mask = wr_data;
                end else if (wr_cmd == 8'hFA) begin
                    if (!m_mask[1]) begin
                        if (!m_lock) begin
                            m_key = wr_data; m_lock = (wr_data != 0); g = 1;
                        end else if (m_fail < 3) begin
                            if (wr_data == m_key) begin m_lock = 0; g = 1; end
                            else m_fail++;
                        end
                    end
                end else if (wr_cmd == 8'h10) begin
                    g = !m_mask[14];
                    if (g) m_leg = wr_data[7:0];
                end else if (wr_cmd == 8'h15) begin
                    g = !m_mask[0] && !m_lock;
                end else begin
                    g = ((grp_sel & m_mask) == 0) && leg_allows(m_leg, grp_sel);
                end
            end
            e_ok = wr_en && g; e_bad = wr_en && !g;
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R11 model ok", wr_ok, e_ok);
            chk("R11 model bad", wr_bad, e_bad);
            chk("R10 model mask", ext_mask, m_mask);
            chk("R9 model legacy", legacy_wp, m_leg);
            chk("R7 model lock", key_locked, m_lock);
            chk("R8 model fails", fail_count, m_fail);
        end
    end

    task automatic wr(input logic [7:0] c, input logic [15:0] d, input logic [15:0] g);
        @(negedge clk);
        wr_en = 1; wr_cmd = c; wr_data = d; grp_sel = g;
        @(negedge clk);
        wr_en = 0; grp_sel = '0;
    endtask

    task automatic do_reset(input logic [15:0] bm, input logic [7:0] bl, input logic [15:0] bk);
        @(negedge clk);
        rst_n = 0; boot_mask = bm; boot_legacy = bl; boot_key = bk;
        repeat (2) @(negedge clk);
        chk("R1 reset mask zero", ext_mask, 0);
        chk("R1 reset lock zero", key_locked, 0);
        chk("R1 reset pulses zero", {wr_ok, wr_bad}, 0);
        rst_n = 1;
        @(negedge clk);
        chk("R1 boot mask", ext_mask, bm);
        chk("R1 boot lock", key_locked, bk != 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog R11 actual=hung expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(16'h0000, 8'h00, 16'h0000);
        wr(8'h21, 16'h0001, 16'h1000); chk("R3 open ordinary", wr_ok, 1);
        wr(8'hFB, 16'h1000, 16'h0);    chk("R5 mask write", wr_ok, 1);
        wr(8'h21, 16'h0001, 16'h1000); chk("R2 VOUT blocked", wr_bad, 1);
        wr(8'h2B, 16'h0001, 16'h0040); chk("R2 CFG allowed", wr_ok, 1);
        wr(8'hFB, 16'h1001, 16'h0);    chk("R5 mask rewrite", wr_ok, 1);
        wr(8'h15, 16'h0, 16'h0);       chk("R6 store bit0", wr_bad, 1);
        wr(8'hFB, 16'h1000, 16'h0);
        wr(8'h15, 16'h0, 16'h0);       chk("R6 store open", wr_ok, 1);
        @(negedge clk);                chk("R11 idle no pulse", {wr_ok, wr_bad}, 0);
        wr(8'h10, 16'h0080, 16'h0);    chk("R9 legacy write", legacy_wp, 8'h80);
        wr(8'h2B, 16'h0, 16'h0040);    chk("R9 80h blocks CFG", wr_bad, 1);
        wr(8'h10, 16'h0040, 16'h0);
        wr(8'h01, 16'h0, 16'h0080);    chk("R9 40h allows OP", wr_ok, 1);
        wr(8'h2B, 16'h0, 16'h0040);    chk("R9 40h blocks CFG", wr_bad, 1);
        wr(8'h10, 16'h0000, 16'h0);
        wr(8'hFA, 16'h1234, 16'h0);    chk("R7 key load", wr_ok, 1);
        chk("R7 lock set", key_locked, 1);
        wr(8'hFB, 16'h0000, 16'h0);    chk("R6 mask blocked locked", wr_bad, 1);
        chk("R10 mask held", ext_mask, 16'h1000);
        wr(8'h15, 16'h0, 16'h0);       chk("R6 store blocked locked", wr_bad, 1);
        wr(8'hFA, 16'h1111, 16'h0);    chk("R7 wrong key", wr_bad, 1);
        chk("R7 fail count", fail_count, 1);
        wr(8'hFA, 16'h1234, 16'h0);    chk("R7 unlock", key_locked, 0);
        wr(8'hFB, 16'h0002, 16'h0);    chk("R5 set psk bit", wr_ok, 1);
        wr(8'hFA, 16'h5555, 16'h0);    chk("R5 key blocked", wr_bad, 1);
        chk("R5 still unlocked", key_locked, 0);
        wr(8'hFB, 16'h8000, 16'h0);    chk("R4 set hwp", wr_ok, 1);
        wr(8'hFB, 16'h0000, 16'h0);    chk("R4 mask blocked", wr_bad, 1);
        chk("R10 hwp kept", ext_mask, 16'h8000);

        do_reset(16'h0000, 8'h00, 16'hBEEF);
        wr(8'hFA, 16'h0001, 16'h0);
        wr(8'hFA, 16'h0002, 16'h0);
        wr(8'hFA, 16'h0003, 16'h0);    chk("R8 three fails", fail_count, 3);
        wr(8'hFA, 16'hBEEF, 16'h0);    chk("R8 right key ignored", wr_bad, 1);
        chk("R8 stays locked", key_locked, 1);
        wr(8'h15, 16'h0, 16'h0);       chk("R6 store sealed", wr_bad, 1);

        do_reset(16'h0000, 8'h00, 16'hBEEF);
        chk("R8 reset clears fails", fail_count, 0);
        wr(8'hFA, 16'hBEEF, 16'h0);    chk("R7 boot key unlock", key_locked, 0);

        repeat (2) @(negedge clk);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule